// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block takes an asynchronous serial line and turns each character on it into a byte in a one-entry holding register. A frame begins with a low start bit. Eight data bits follow, then a parity bit if parity is enabled, then a high stop bit. The receiver does not generate its own baud rate. It is driven by a sampling enable that pulses sixteen times per bit period. It checks each bit at the middle of its cell. Data bits are gathered in a shift register, and the bit order is chosen by a static input: most-significant first or least-significant first.

When a frame ends, the byte moves from the shift register to the holding register. If the holding register still contains an unread byte, the new byte is dropped and an overrun flag is raised instead. Four sticky status flags report events:
- data-ready, which also serves as the interrupt flag
- overrun
- parity error
- framing error

Software clears a flag only by writing 1 to its bit. A read strobe takes the byte out of the holding register. The read does not touch any interrupt flag.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `busy`, `buf_full`, `irq_full`, `irq_ovr`, `err_par` and `err_frm` are all 0.
- R2: A frame is a low start bit, 8 data bits, a parity bit only when `par_en`=1, and a high stop bit. The received byte appears on `rd_data`.
- R3: With `msb_first`=1, the first data bit after the start bit is bit 7. With `msb_first`=0, it is bit 0.
- R4: `busy` is 1 from the sample tick that first sees the line low until the stop bit is sampled at mid-cell. It is 0 after that.
- R5: A low pulse that has already ended at the start bit's midpoint (8 ticks) is a false start. It leaves the buffer, the data and every flag unchanged.
- R6: A frame that completes while `buf_full`=0 loads `rd_data` and sets both `buf_full` and `irq_full`.
- R7: A frame that completes while `buf_full`=1 sets `irq_ovr`. The unread byte on `rd_data` is kept, and the new byte is discarded.
- R8: A pulse on `rd_strobe` clears `buf_full` and leaves `irq_full` as it was.
- R9: `clr_w1c` bit 0 clears `irq_full`, bit 1 clears `irq_ovr`, bit 2 clears `err_par` and bit 3 clears `err_frm`. A 0 bit leaves its flag unchanged. Flags clear in no other way.
- R10: With `par_en`=1, the expected parity bit is the XOR of the data bits (even parity, `par_odd`=0) or its inverse (odd parity, `par_odd`=1). A mismatch sets `err_par`.
- R11: A low stop bit sets `err_frm` and still delivers the byte as in R6/R7. The receiver then waits for the line to go high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Oversampling enable, OVS pulses per bit period |
| rxd | input | 1 | Serial data line, idles high |
| par_en | input | 1 | 1: frame carries a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| msb_first | input | 1 | 1: data bit 7 arrives first |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| clr_w1c | input | 4 | Write-1-to-clear: {frm, par, ovr, full} |
| rd_data | output | DATA_W | Holding register contents |
| buf_full | output | 1 | Holding register contains an unread byte |
| busy | output | 1 | Frame being received |
| irq_full | output | 1 | Sticky data-ready interrupt flag |
| irq_ovr | output | 1 | Sticky overrun flag |
| err_par | output | 1 | Sticky parity error flag |
| err_frm | output | 1 | Sticky framing error flag |

## Verification
The bench uses the default parameters: DATA_W=8, OVS=16, and a two-stage input synchronizer. It pulses `samp_en` on every second clock, so one bit lasts 32 clocks and a frame is short enough to run many scenarios. At this rate a false start can be made shorter than half a bit cell, and the synchronizer delay stays well inside the mid-cell margin. With these settings the bench exercises both bit orders, both parity senses, back-to-back frames without a read (overrun), and a held-low stop bit followed by a clean resynchronising frame.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_HOLD  = 3'd5
  } rx_state_t;

  localparam int FLAG_FULL = 0;
  localparam int FLAG_OVR  = 1;
  localparam int FLAG_PAR  = 2;
  localparam int FLAG_FRM  = 3;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_d;

  always_comb begin
    q_d = {q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_d;
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rxu_deframer.sv
module rxu_deframer
  import rxu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              msb_first,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] frame_data,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF    = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

  rx_state_t         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              acc_q, acc_d;
  logic              perr_q, perr_d;
  logic              cell_end;

  assign cell_end = tick && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    acc_d   = acc_q;
    perr_d  = perr_q;
    case (state_q)
      ST_IDLE: begin
        if (tick && !rxd) begin
          state_d = ST_START;
          cnt_d   = '0;
          bit_d   = '0;
          acc_d   = 1'b0;
          perr_d  = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt_q == HALF) begin
            cnt_d   = '0;
            state_d = rxd ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (cell_end) begin
          cnt_d = '0;
          acc_d = acc_q ^ rxd;
          if (msb_first) sh_d = {sh_q[DATA_W-2:0], rxd};
          else           sh_d = {rxd, sh_q[DATA_W-1:1]};
          if (bit_q == LASTBIT) state_d = par_en ? ST_PAR : ST_STOP;
          else                  bit_d   = bit_q + 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (cell_end) begin
          cnt_d   = '0;
          perr_d  = (acc_q ^ rxd) != par_odd;
          state_d = ST_STOP;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (cell_end) begin
          cnt_d   = '0;
          state_d = rxd ? ST_IDLE : ST_HOLD;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (rxd) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
    end
  end

  assign busy       = (state_q == ST_START) || (state_q == ST_DATA) ||
                      (state_q == ST_PAR)   || (state_q == ST_STOP);
  assign done       = (state_q == ST_STOP) && cell_end;
  assign frame_data = sh_q;
  assign par_bad    = perr_q;
  assign stop_bad   = !rxd;
endmodule

// File: rtl/rxu_status.sv
module rxu_status
  import rxu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_W-1:0]    frame_data,
  input  logic                 par_bad,
  input  logic                 stop_bad,
  input  logic                 rd_strobe,
  input  logic [NUM_FLAGS-1:0] clr_w1c,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 buf_full,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [DATA_W-1:0]    data_q, data_d;
  logic                 full_q, full_d;
  logic [NUM_FLAGS-1:0] flag_q, flag_d;
  logic [NUM_FLAGS-1:0] flag_set;
  logic                 occupied;
  logic                 accept;

  assign occupied = full_q && !rd_strobe;
  assign accept   = done && !occupied;

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_FULL] = accept;
    flag_set[FLAG_OVR]  = done && occupied;
    flag_set[FLAG_PAR]  = done && par_bad;
    flag_set[FLAG_FRM]  = done && stop_bad;
  end

  always_comb begin
    data_d = accept ? frame_data : data_q;
    if (accept)         full_d = 1'b1;
    else if (rd_strobe) full_d = 1'b0;
    else                full_d = full_q;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flag_d[i] = flag_set[i] | (flag_q[i] & ~clr_w1c[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      flag_q <= '0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      flag_q <= flag_d;
    end
  end

  assign rd_data  = data_q;
  assign buf_full = full_q;
  assign flags    = flag_q;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import rxu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              msb_first,
  input  logic              rd_strobe,
  input  logic [3:0]        clr_w1c,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              busy,
  output logic              irq_full,
  output logic              irq_ovr,
  output logic              err_par,
  output logic              err_frm
);
  logic                 rxd_s;
  logic                 done;
  logic [DATA_W-1:0]    frame_data;
  logic                 par_bad;
  logic                 stop_bad;
  logic [NUM_FLAGS-1:0] flags;

  rxu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rxd_s)
  );

  rxu_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_defr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (samp_en),
    .rxd       (rxd_s),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .msb_first (msb_first),
    .busy      (busy),
    .done      (done),
    .frame_data(frame_data),
    .par_bad   (par_bad),
    .stop_bad  (stop_bad)
  );

  rxu_status #(.DATA_W(DATA_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .frame_data(frame_data),
    .par_bad   (par_bad),
    .stop_bad  (stop_bad),
    .rd_strobe (rd_strobe),
    .clr_w1c   (clr_w1c),
    .rd_data   (rd_data),
    .buf_full  (buf_full),
    .flags     (flags)
  );

  assign irq_full = flags[FLAG_FULL];
  assign irq_ovr  = flags[FLAG_OVR];
  assign err_par  = flags[FLAG_PAR];
  assign err_frm  = flags[FLAG_FRM];
endmodule

// File: rtl/rxu_checker.sv
module rxu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              buf_full,
  input logic              rd_strobe,
  input logic [3:0]        clr_w1c,
  input logic              irq_full,
  input logic              irq_ovr,
  input logic              err_par,
  input logic [DATA_W-1:0] rd_data
);
  assert_full_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> irq_full);

  assert_ovr_keeps_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovr) |-> $stable(rd_data));

  assert_read_keeps_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_full && rd_strobe && !clr_w1c[0]) |=> irq_full);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovr && !clr_w1c[1]) |=> irq_ovr);

  assert_par_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c[2] && !busy) |=> !err_par);

  assert_no_load_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$rose(buf_full));
endmodule

bind serial_rx_unit rxu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .buf_full (buf_full),
  .rd_strobe(rd_strobe),
  .clr_w1c  (clr_w1c),
  .irq_full (irq_full),
  .irq_ovr  (irq_ovr),
  .err_par  (err_par),
  .rd_data  (rd_data)
);

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
  localparam int OVS = 16;
  localparam int CYC_PER_BIT = OVS * 2;

  logic       clk;
  logic       rst_n;
  logic       samp_en;
  logic       rxd;
  logic       par_en;
  logic       par_odd;
  logic       msb_first;
  logic       rd_strobe;
  logic [3:0] clr_w1c;
  logic [7:0] rd_data;
  logic       buf_full, busy, irq_full, irq_ovr, err_par, err_frm;

  serial_rx_unit u0 (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .msb_first(msb_first),
    .rd_strobe(rd_strobe), .clr_w1c(clr_w1c), .rd_data(rd_data),
    .buf_full(buf_full), .busy(busy), .irq_full(irq_full),
    .irq_ovr(irq_ovr), .err_par(err_par), .err_frm(err_frm)
  );

  typedef struct {
    string      tag;
    logic [7:0] data;
    logic       full, irq, ovr, par, frm;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  logic [7:0] m_data = 8'h00;
  logic       m_full = 0, m_irq = 0, m_ovr = 0, m_par = 0, m_frm = 0;

  initial clk = 0;
  always #5 clk = ~clk;

  initial begin
    samp_en = 0;
    forever @(negedge clk) samp_en = ~samp_en;
  end

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic exp_t snapshot(input string tag);
    exp_t e;
    e.tag = tag; e.data = m_data; e.full = m_full; e.irq = m_irq;
    e.ovr = m_ovr; e.par = m_par; e.frm = m_frm;
    return e;
  endfunction

  // monitor: compare on each end of busy
  bit busy_seen = 0;
  always @(negedge clk) begin
    if (busy_seen && !busy) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected frame end", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " rd_data"},  rd_data,  e.data);
        check({e.tag, " buf_full"}, buf_full, e.full);
        check({e.tag, " irq_full"}, irq_full, e.irq);
        check({e.tag, " irq_ovr"},  irq_ovr,  e.ovr);
        check({e.tag, " err_par"},  err_par,  e.par);
        check({e.tag, " err_frm"},  err_frm,  e.frm);
      end
    end
    busy_seen = busy;
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (CYC_PER_BIT) @(negedge clk);
  endtask

  task automatic send_frame(input string tag, input logic [7:0] d,
                            input bit flip_par, input bit stop_low);
    logic pbit;
    if (m_full) m_ovr = 1;
    else begin m_data = d; m_full = 1; m_irq = 1; end
    if (par_en && flip_par) m_par = 1;
    if (stop_low) m_frm = 1;
    exp_q.push_back(snapshot(tag));
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      hold_bit(msb_first ? d[7-i] : d[i]);
      if (i == 2) check("R4 busy mid-frame", busy, 1);
    end
    if (par_en) begin
      pbit = (^d) ^ par_odd ^ flip_par;
      hold_bit(pbit);
    end
    hold_bit(!stop_low);
    hold_bit(1'b1);
    hold_bit(1'b1);
    check("R4 busy after frame", busy, 0);
  endtask

  task automatic read_buf();
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    m_full = 0;
    check("R8 buf_full after read", buf_full, 0);
    check("R8 irq_full kept by read", irq_full, m_irq);
  endtask

  task automatic clear_flags(input logic [3:0] m);
    clr_w1c = m;
    @(negedge clk);
    clr_w1c = 4'h0;
    if (m[0]) m_irq = 0;
    if (m[1]) m_ovr = 0;
    if (m[2]) m_par = 0;
    if (m[3]) m_frm = 0;
    check("R9 irq_full", irq_full, m_irq);
    check("R9 irq_ovr",  irq_ovr,  m_ovr);
    check("R9 err_par",  err_par,  m_par);
    check("R9 err_frm",  err_frm,  m_frm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rxd = 1; par_en = 0; par_odd = 0; msb_first = 1;
    rd_strobe = 0; clr_w1c = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 buf_full", buf_full, 0);
    check("R1 flags", {irq_full, irq_ovr, err_par, err_frm}, 0);

    // R2 R3 MSB first, no parity
    send_frame("R2 R3 R6 msb 0xA5", 8'hA5, 0, 0);
    read_buf();
    clear_flags(4'b0001);

    // R3 LSB first
    msb_first = 0;
    send_frame("R3 lsb 0x3C", 8'h3C, 0, 0);
    send_frame("R7 overrun keeps 0x3C", 8'h96, 0, 0);
    read_buf();
    clear_flags(4'b0010);   // R9: ovr only, irq_full must stay
    clear_flags(4'b0001);

    // R10 parity even and odd
    msb_first = 1; par_en = 1; par_odd = 0;
    send_frame("R10 even good 0x5A", 8'h5A, 0, 0);
    read_buf();
    par_odd = 1;
    send_frame("R10 odd good 0x81", 8'h81, 0, 0);
    read_buf();
    send_frame("R10 odd bad 0x81", 8'h81, 1, 0);
    read_buf();
    par_odd = 0;
    send_frame("R10 even bad 0x0F", 8'h0F, 1, 0);
    read_buf();
    clear_flags(4'b0100);
    clear_flags(4'b0001);
    par_en = 0;

    // R5 false start
    exp_q.push_back(snapshot("R5 false start"));
    rxd = 0;
    repeat (6) @(negedge clk);
    rxd = 1;
    repeat (CYC_PER_BIT * 2) @(negedge clk);
    check("R5 rd_data unchanged", rd_data, m_data);
    check("R5 buf_full unchanged", buf_full, m_full);

    // R11 framing error then recovery
    send_frame("R11 frame err 0x77", 8'h77, 0, 1);
    read_buf();
    clear_flags(4'b1001);
    send_frame("R11 resync 0x42", 8'h42, 0, 0);
    read_buf();
    clear_flags(4'b1111);

    repeat (10) @(negedge clk);
    check("R4 no pending frames", exp_q.size(), 0);
    finish_run();
  end
endmodule